// File: doc/BRIEF.md
# Short Transport-Layer Test Pattern Checker

This block checks the short transport-layer test pattern on the receive lanes of a multi-lane serial link. It sits after frame alignment and character replacement. Each lane delivers one octet per clock together with a frame-start marker. The frame length F (octets per frame) is configurable as 1, 2, 4 or 8. The test pattern lasts exactly one frame and repeats without a break, so each octet position in a frame has one fixed expected value. The table of those values depends on F.

For each lane, a position counter restarts on the frame-start marker and selects the expected octet. Any octet that differs sets a sticky error bit for that lane. A shared alarm output combines the lane errors that are not masked. A configuration input selects whether the alarm is active high or active low. Software turns the checker on with an enable input and clears error bits with a write-one-to-clear pulse vector.

Top module: `short_pattern_checker`

## Requirements
- R1: While reset is held, and in the first cycle after it, every bit of `err_o` is 0 and `alarm_o` is at its inactive level.
- R2: `frame_len_i` selects F as follows: 0 gives F=1, 1 gives F=2, 2 gives F=4 and 3 gives F=8. With F=1 every octet must be 0xF1. With F=2 each frame must be 0xF1 then 0xE2.
- R3: With F=4 each frame must be 0xF1, 0xE2, 0xD3, 0xC4. With F=8 each frame must be 0xF1, 0xE2, 0xD3, 0xC4, 0xB5, 0xA6, 0x97, 0x81.
- R4: The octet that arrives with a frame-start marker is compared against the first entry of the table. Each later octet is compared against the next entry, and the position wraps to 0 after entry F-1.
- R5: After enable rises, a lane ignores every octet that arrives before its first frame-start marker.
- R6: While `enable_i` is 0, no error is recorded and `err_o` clears to 0 on the next clock. The lane must also see a new frame-start marker before it checks again.
- R7: A mismatch sets the lane's `err_o` bit in the next cycle, and the bit stays set. A 1 on `clear_i[n]` clears bit n on the next clock. If a new mismatch arrives in the same cycle as the clear, the bit stays set.
- R8: With `alarm_pol_i`=1, `alarm_o` is 1 exactly when some lane has `err_o`=1 and `mask_i`=0. A lane whose mask bit is 1 does not affect the alarm.
- R9: With `alarm_pol_i`=0, the alarm is inverted: `alarm_o` is 0 exactly when some unmasked lane has an error.
- R10: Each lane has its own position counter, arming state and error bit. An error on one lane never changes another lane's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Checker enable |
| frame_len_i | input | 2 | Frame length code: 0=1, 1=2, 2=4, 3=8 octets |
| lane_octet_i | input | LANES*8 | One octet per lane; lane n is in bits [8n+7:8n] |
| lane_sof_i | input | LANES | Frame-start marker per lane |
| clear_i | input | LANES | Write-one-to-clear pulse per lane error bit |
| mask_i | input | LANES | 1 removes that lane from the alarm |
| alarm_pol_i | input | 1 | 1 = alarm active high, 0 = active low |
| err_o | output | LANES | Sticky error bit per lane |
| alarm_o | output | 1 | Combined alarm of the unmasked lane errors |

## Verification
Two functions can act on an error bit in the same cycle: the software clear pulse and the recording of a new mismatch. The bench provokes this directly. It has a lane with an error already set receive a corrupted octet in the same cycle as its clear pulse, and it expects the bit to stay set. It then sends a clean octet with the clear pulse, and it expects the bit to drop. The random phase raises clear pulses and corrupted octets independently on every lane, so the two often meet, and a reference model applies the rule that a set wins over a clear. A second collision, a frame-start marker in the same cycle that enable rises, is judged the same way: that octet is checked immediately.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int OCTET_W = 8;
    localparam int MAX_F   = 8;
    localparam int POS_W   = $clog2(MAX_F);

    typedef logic [OCTET_W-1:0] octet_t;
    typedef logic [POS_W-1:0]   pos_t;

    typedef struct packed {
        logic armed;
        pos_t pos;
        logic err;
    } lane_state_t;

    function automatic octet_t pattern_octet(input pos_t idx);
        octet_t v;
        case (idx)
            3'd0:    v = 8'hF1;
            3'd1:    v = 8'hE2;
            3'd2:    v = 8'hD3;
            3'd3:    v = 8'hC4;
            3'd4:    v = 8'hB5;
            3'd5:    v = 8'hA6;
            3'd6:    v = 8'h97;
            default: v = 8'h81;
        endcase
        return v;
    endfunction

    function automatic pos_t frame_wrap_mask(input logic [1:0] code);
        return pos_t'((1 << code) - 1);
    endfunction
endpackage

// File: rtl/spc_lane.sv
module spc_lane
    import spc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       enable_i,
    input  logic [1:0] frame_len_i,
    input  octet_t     octet_i,
    input  logic       sof_i,
    input  logic       clear_i,
    output logic       err_o
);
    lane_state_t st_d, st_q;

    pos_t   wrap_mask;
    pos_t   cur_idx;
    logic   do_check;
    logic   mismatch;

    always_comb begin
        st_d      = st_q;
        wrap_mask = frame_wrap_mask(frame_len_i);
        cur_idx   = sof_i ? '0 : (st_q.pos & wrap_mask);
        do_check  = enable_i && (sof_i || st_q.armed);
        mismatch  = do_check && (octet_i != pattern_octet(cur_idx));

        if (!enable_i) begin
            st_d.armed = 1'b0;
            st_d.pos   = '0;
            st_d.err   = 1'b0;
        end else begin
            st_d.armed = st_q.armed | sof_i;
            st_d.pos   = (cur_idx + pos_t'(1)) & wrap_mask;
            st_d.err   = (st_q.err & ~clear_i) | mismatch;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = st_q.err;
endmodule

// File: rtl/spc_alarm.sv
module spc_alarm #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] err_i,
    input  logic [LANES-1:0] mask_i,
    input  logic             pol_i,
    output logic             alarm_o
);
    logic any_active;

    always_comb begin
        any_active = |(err_i & ~mask_i);
        alarm_o    = pol_i ? any_active : ~any_active;
    end
endmodule

// File: rtl/short_pattern_checker.sv
module short_pattern_checker #(
    parameter int LANES = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               enable_i,
    input  logic [1:0]         frame_len_i,
    input  logic [LANES*8-1:0] lane_octet_i,
    input  logic [LANES-1:0]   lane_sof_i,
    input  logic [LANES-1:0]   clear_i,
    input  logic [LANES-1:0]   mask_i,
    input  logic               alarm_pol_i,
    output logic [LANES-1:0]   err_o,
    output logic               alarm_o
);
    localparam int OW = spc_pkg::OCTET_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        spc_lane u_lane (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .enable_i   (enable_i),
            .frame_len_i(frame_len_i),
            .octet_i    (lane_octet_i[l*OW +: OW]),
            .sof_i      (lane_sof_i[l]),
            .clear_i    (clear_i[l]),
            .err_o      (err_o[l])
        );
    end

    spc_alarm #(.LANES(LANES)) u_alarm (
        .err_i  (err_o),
        .mask_i (mask_i),
        .pol_i  (alarm_pol_i),
        .alarm_o(alarm_o)
    );
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
    parameter int LANES = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             enable_i,
    input logic [LANES-1:0] lane_sof_i,
    input logic [LANES-1:0] clear_i,
    input logic [LANES-1:0] mask_i,
    input logic             alarm_pol_i,
    input logic [LANES-1:0] err_o,
    input logic             alarm_o
);
    AST_DISABLED_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (err_o == '0)); // R6

    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && clear_i == '0) |=> ((err_o & $past(err_o)) == $past(err_o))); // R7

    AST_UNARMED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(enable_i) && lane_sof_i == '0) |=> (err_o == '0)); // R5

    AST_ALARM_HIGH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alarm_pol_i && (err_o & ~mask_i) == '0) |-> !alarm_o); // R8

    AST_ALARM_LOW_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!alarm_pol_i && (err_o & ~mask_i) != '0) |-> !alarm_o); // R9
endmodule

bind short_pattern_checker spc_checker #(.LANES(LANES)) u_spc_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .lane_sof_i (lane_sof_i),
    .clear_i    (clear_i),
    .mask_i     (mask_i),
    .alarm_pol_i(alarm_pol_i),
    .err_o      (err_o),
    .alarm_o    (alarm_o)
);

// File: tb/short_pattern_checker_tb_top.sv
`timescale 1ns/1ps
module short_pattern_checker_tb_top;
    localparam int LANES = 8;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               enable;
    logic [1:0]         flen;
    logic [LANES*8-1:0] octets;
    logic [LANES-1:0]   sof, clr, mask;
    logic               pol;
    logic [LANES-1:0]   err;
    logic               alarm;

    always #2 clk = ~clk;

    short_pattern_checker #(.LANES(LANES)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .frame_len_i(flen),
        .lane_octet_i(octets), .lane_sof_i(sof), .clear_i(clr), .mask_i(mask),
        .alarm_pol_i(pol), .err_o(err), .alarm_o(alarm)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [LANES-1:0] m_err, m_armed;
    int               m_pos [LANES];
    int               tx_pos[LANES];

    function automatic logic [7:0] ref_octet(input int i);
        case (i)
            0: return 8'hF1; 1: return 8'hE2; 2: return 8'hD3; 3: return 8'hC4;
            4: return 8'hB5; 5: return 8'hA6; 6: return 8'h97; default: return 8'h81;
        endcase
    endfunction

    function automatic int f_of(input logic [1:0] c);
        return 1 << c;
    endfunction

    function automatic logic ref_alarm(input logic [LANES-1:0] e, input logic [LANES-1:0] m, input logic p);
        logic any = |(e & ~m);
        return p ? any : ~any;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (err !== m_err) begin
            fails++;
            $display("FAIL %s err_o actual=%b expected=%b", tag, err, m_err);
        end
        checks++;
        if (alarm !== ref_alarm(m_err, mask, pol)) begin
            fails++;
            $display("FAIL %s alarm_o actual=%b expected=%b", pol ? "R8" : "R9",
                     alarm, ref_alarm(m_err, mask, pol));
        end
    endtask

    // Drive one lane from its transmit position; corrupt flips bits
    task automatic drive_lane(input int l, input logic [7:0] corrupt);
        int f = f_of(flen);
        tx_pos[l] = tx_pos[l] % f;
        sof[l] = (tx_pos[l] == 0);
        octets[l*8 +: 8] = ref_octet(tx_pos[l]) ^ corrupt;
        tx_pos[l] = (tx_pos[l] + 1) % f;
    endtask

    // Apply model for the inputs now driven, then clock and compare
    task automatic step(input string tag);
        int f = f_of(flen);
        for (int l = 0; l < LANES; l++) begin
            logic chk; int idx; logic mis;
            if (!enable) begin
                m_err[l] = 0; m_armed[l] = 0; m_pos[l] = 0;
            end else begin
                chk = sof[l] || m_armed[l];
                idx = sof[l] ? 0 : (m_pos[l] % f);
                mis = chk && (octets[l*8 +: 8] != ref_octet(idx));
                m_err[l]   = (m_err[l] & ~clr[l]) | mis;
                m_armed[l] = m_armed[l] | sof[l];
                m_pos[l]   = (idx + 1) % f;
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic clean_frames(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            clr = '0;
            for (int l = 0; l < LANES; l++) drive_lane(l, 8'h00);
            step(tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; enable = 0; flen = 2'd3; octets = '0; sof = '0;
        clr = '0; mask = '0; pol = 1'b1;
        m_err = '0; m_armed = '0;
        for (int l = 0; l < LANES; l++) begin m_pos[l] = 0; tx_pos[l] = 0; end
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1;
        step("R1");

        // R5: garbage before first marker is ignored
        enable = 1; flen = 2'd3;
        for (int i = 0; i < 5; i++) begin
            sof = '0; octets = {LANES{8'h5A}};
            step("R5");
        end
        // R3: clean F=8 then F=4
        for (int l = 0; l < LANES; l++) tx_pos[l] = 0;
        clean_frames(40, "R3");
        flen = 2'd2;
        for (int l = 0; l < LANES; l++) tx_pos[l] = 0;
        clean_frames(24, "R3");
        // R2: F=2 and F=1
        flen = 2'd1;
        for (int l = 0; l < LANES; l++) tx_pos[l] = 0;
        clean_frames(12, "R2");
        flen = 2'd0;
        clean_frames(6, "R2");
        // R10: one corrupted lane, others unaffected
        for (int l = 0; l < LANES; l++) drive_lane(l, (l == 3) ? 8'h01 : 8'h00);
        step("R10");
        clean_frames(3, "R10");
        // R4: F=4, a marker arrives mid-frame and restarts the position
        flen = 2'd2; clr = '1;
        for (int l = 0; l < LANES; l++) tx_pos[l] = 0;
        for (int l = 0; l < LANES; l++) drive_lane(l, 8'h00);
        step("R4");
        clr = '0;
        for (int l = 0; l < LANES; l++) drive_lane(l, 8'h00);
        step("R4");
        for (int l = 0; l < LANES; l++) tx_pos[l] = 0;
        clean_frames(8, "R4");
        // R7: clear and a new mismatch in the same cycle on lane 0
        drive_lane(0, 8'h80);
        for (int l = 1; l < LANES; l++) drive_lane(l, 8'h00);
        step("R7");
        clr = 8'h01;
        drive_lane(0, 8'h10);
        for (int l = 1; l < LANES; l++) drive_lane(l, 8'h00);
        step("R7");
        for (int l = 0; l < LANES; l++) drive_lane(l, 8'h00);
        step("R7");
        clr = '0;
        clean_frames(2, "R7");
        // R8 / R9: masks and polarity with an error held
        drive_lane(5, 8'hFF);
        for (int l = 0; l < LANES; l++) if (l != 5) drive_lane(l, 8'h00);
        step("R8");
        mask = 8'h20; clean_frames(1, "R8");
        pol = 0;      clean_frames(1, "R9");
        mask = 8'h00; clean_frames(1, "R9");
        // R6: disable clears errors and drops arming
        enable = 0; clean_frames(2, "R6");
        enable = 1; sof = '0; octets = '0; step("R6");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) == 0) enable = ~enable;
            if ($urandom_range(0, 149) == 0) flen = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 49) == 0) mask = LANES'($urandom);
            if ($urandom_range(0, 99) == 0) pol = ~pol;
            for (int l = 0; l < LANES; l++) begin
                clr[l] = ($urandom_range(0, 19) == 0);
                if ($urandom_range(0, 59) == 0) tx_pos[l] = $urandom_range(0, 7);
                drive_lane(l, ($urandom_range(0, 39) == 0) ? 8'($urandom_range(1, 255)) : 8'h00);
                if ($urandom_range(0, 79) == 0) sof[l] = ~sof[l];
            end
            step("R7");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule